// File: doc/BRIEF.md
# Planar Frame Buffer Write Datapath

This block sits between a CPU bus and a frame buffer that is split into four byte-wide planes sharing one address space. Every CPU access touches the same address in all four planes at once. A CPU read fetches all four bytes and stores them in four per-plane holding latches, while only one of those bytes, chosen by a read-plane register, goes back to the CPU. A CPU write sends one byte that is combined, separately in each plane, with that plane's latched byte. The combination uses a shared logical function and a per-bit mask. The results are written to every plane that the plane-enable register allows.

The second operand of each plane's logic unit is the byte latched by the most recent read, which may come from any address. It is not the current content of the address being written. A single read followed by writes in latch-copy mode, or with an all-zero bit mask, therefore moves four bytes per write, which suits block copies and multi-plane pattern fills. Software sets the function, mask, plane enables, write mode and read plane through an index/data register port pair.

Top module: `planar_write_path`

## Requirements
- R1: After reset: `cpu_rvalid`, `mem_rd` and `mem_we` are 0. All latches are 0. The configuration is bit mask 0xFF, plane enable 0xF, function pass, write mode 0 and read plane 0, so a first write stores the CPU byte unchanged in all four planes.
- R2: A `cpu_rd` strobe in cycle T drives `mem_rd`=1 with `mem_addr` equal to the strobed address in cycle T+1. In cycle T+2, `cpu_rvalid`=1 and `cpu_rdata` holds byte p of `mem_rdata` (bits 8p+7..8p), where p is read-plane register index 4, bits 1:0, as it stood at the strobe.
- R3: Every read loads all four latches from the fetched word, whichever plane is returned to the CPU.
- R4: The latches change only when a read completes. Any number of writes leaves them unchanged.
- R5: The function register (index 2, bits 4:3) selects the operation for all planes: 00 passes the CPU byte, 01 ANDs it with the plane's latch, 10 ORs, and 11 XORs.
- R6: In write mode 0, bit mask register (index 0) bit b = 1 writes the function result at bit b, and bit b = 0 writes the latch bit. A mask of 0x00 writes the latches unchanged.
- R7: Write mode register (index 3, bit 0) = 1 writes the four latch bytes unchanged, ignoring the CPU byte, the function and the mask.
- R8: `mem_we` bit p, for plane p, equals plane-enable register (index 1) bit p. Disabled planes keep their stored byte.
- R9: A `cpu_wr` strobe in cycle T drives `mem_addr`, `mem_wdata` and `mem_we` in cycle T+1 only. `mem_we` is 0 in every other cycle.
- R10: If `cpu_rd` and `cpu_wr` are both high in one cycle, the read is performed and the write is dropped.
- R11: A write strobed in the cycle in which a read's data returns uses the just-fetched bytes as its latch operand.
- R12: With `reg_sel`=0, `reg_wr` loads the 3-bit register index. With `reg_sel`=1, it writes the indexed register, and the index is kept for further data writes. Indices 5 to 7 are ignored. Register changes apply to CPU strobes in later cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | ADDR_W | CPU access address |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_wdata | input | 8 | CPU write byte |
| cpu_rdata | output | 8 | Byte returned from the selected plane |
| cpu_rvalid | output | 1 | `cpu_rdata` is valid this cycle |
| reg_wr | input | 1 | Register port write strobe |
| reg_sel | input | 1 | 0 = index write, 1 = data write |
| reg_wdata | input | 8 | Register port data |
| mem_addr | output | ADDR_W | Frame buffer address |
| mem_rd | output | 1 | Frame buffer read cycle |
| mem_we | output | 4 | Per-plane write enable |
| mem_wdata | output | 32 | Write bytes, plane p at bits 8p+7..8p |
| mem_rdata | input | 32 | Read word, valid in the `mem_rd` cycle |

## Verification
Two functions can fall in the same cycle: a read completing, which reloads the latches, and a write taking its latch operand. The bench strobes a write in the cycle right after a read strobe, while the latches still hold an older, deliberately different pattern. In latch-copy mode, the written word is judged correct only if it equals the newly fetched word rather than the stale one. Simultaneous read and write strobes are also driven together, and the test checks that the memory contents at the shared address stay untouched while the read still returns its data.

// File: rtl/planar_pkg.sv
package planar_pkg;
    localparam int PLANES = 4;
    localparam int BYTE_W = 8;
    localparam int BUS_W  = PLANES * BYTE_W;
    localparam int IDX_W  = 3;
    localparam int PSEL_W = $clog2(PLANES);
    localparam int FN_LSB = 3;

    typedef enum logic [1:0] {
        FN_PASS = 2'b00,
        FN_AND  = 2'b01,
        FN_OR   = 2'b10,
        FN_XOR  = 2'b11
    } alu_fn_e;

    typedef enum logic {
        WM_COMBINE = 1'b0,
        WM_LATCH   = 1'b1
    } wmode_e;

    localparam logic [IDX_W-1:0] IX_MASK     = 3'd0;
    localparam logic [IDX_W-1:0] IX_PLANE_EN = 3'd1;
    localparam logic [IDX_W-1:0] IX_FUNC     = 3'd2;
    localparam logic [IDX_W-1:0] IX_MODE     = 3'd3;
    localparam logic [IDX_W-1:0] IX_RSEL     = 3'd4;

    typedef struct packed {
        logic [BYTE_W-1:0] bit_mask;
        logic [PLANES-1:0] plane_en;
        alu_fn_e           fn;
        wmode_e            mode;
        logic [PSEL_W-1:0] rd_plane;
    } cfg_t;
endpackage

// File: rtl/planar_regs.sv
module planar_regs
    import planar_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_sel,
    input  logic [BYTE_W-1:0] reg_wdata,
    output cfg_t              cfg
);
    typedef struct packed {
        logic [IDX_W-1:0] idx;
        cfg_t             cfg;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (reg_wr) begin
            if (!reg_sel) begin
                regs_d.idx = reg_wdata[IDX_W-1:0];
            end else begin
                case (regs_q.idx)
                    IX_MASK:     regs_d.cfg.bit_mask = reg_wdata;
                    IX_PLANE_EN: regs_d.cfg.plane_en = reg_wdata[PLANES-1:0];
                    IX_FUNC:     regs_d.cfg.fn = alu_fn_e'(reg_wdata[FN_LSB+1:FN_LSB]);
                    IX_MODE:     regs_d.cfg.mode = wmode_e'(reg_wdata[0]);
                    IX_RSEL:     regs_d.cfg.rd_plane = reg_wdata[PSEL_W-1:0];
                    default:     ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q.idx          <= '0;
            regs_q.cfg.bit_mask <= '1;
            regs_q.cfg.plane_en <= '1;
            regs_q.cfg.fn       <= FN_PASS;
            regs_q.cfg.mode     <= WM_COMBINE;
            regs_q.cfg.rd_plane <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign cfg = regs_q.cfg;

    // R12: the index only moves on an index write
    p_index_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && !reg_sel) |=> $stable(regs_q.idx));

    // R12: data writes to an unused index leave the configuration alone
    p_unused_index_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel && regs_q.idx > IX_RSEL) |=> $stable(regs_q.cfg));
endmodule

// File: rtl/planar_plane_alu.sv
module planar_plane_alu
    import planar_pkg::*;
#(
    parameter int W = BYTE_W
) (
    input  logic [W-1:0] cpu_byte,
    input  logic [W-1:0] latch_byte,
    input  alu_fn_e      fn,
    input  wmode_e       mode,
    input  logic [W-1:0] bit_mask,
    output logic [W-1:0] out_byte
);
    logic [W-1:0] fn_out;

    always_comb begin
        case (fn)
            FN_AND:  fn_out = cpu_byte & latch_byte;
            FN_OR:   fn_out = cpu_byte | latch_byte;
            FN_XOR:  fn_out = cpu_byte ^ latch_byte;
            default: fn_out = cpu_byte;
        endcase
    end

    always_comb begin
        if (mode == WM_LATCH) begin
            out_byte = latch_byte;
        end else begin
            out_byte = (fn_out & bit_mask) | (latch_byte & ~bit_mask);
        end
    end
endmodule

// File: rtl/planar_write_path.sv
module planar_write_path
    import planar_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    input  logic [BYTE_W-1:0] cpu_wdata,
    output logic [BYTE_W-1:0] cpu_rdata,
    output logic              cpu_rvalid,
    input  logic              reg_wr,
    input  logic              reg_sel,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic [PLANES-1:0] mem_we,
    output logic [BUS_W-1:0]  mem_wdata,
    input  logic [BUS_W-1:0]  mem_rdata
);
    typedef struct packed {
        logic              rd_pend;
        logic [PSEL_W-1:0] rd_plane;
        logic [ADDR_W-1:0] addr;
        logic [PLANES-1:0] we;
        logic [BUS_W-1:0]  wdata;
        logic [BUS_W-1:0]  latch;
        logic [BYTE_W-1:0] rdata;
        logic              rvalid;
    } st_t;

    st_t st_d, st_q;
    cfg_t cfg;
    logic [BUS_W-1:0] op_latch;
    logic [BUS_W-1:0] wr_bytes;

    planar_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .cfg       (cfg)
    );

    // A read finishing this cycle forwards its fetched bytes as the operand
    assign op_latch = st_q.rd_pend ? mem_rdata : st_q.latch;

    for (genvar p = 0; p < PLANES; p++) begin : g_plane
        planar_plane_alu #(.W(BYTE_W)) u_alu (
            .cpu_byte   (cpu_wdata),
            .latch_byte (op_latch[p*BYTE_W +: BYTE_W]),
            .fn         (cfg.fn),
            .mode       (cfg.mode),
            .bit_mask   (cfg.bit_mask),
            .out_byte   (wr_bytes[p*BYTE_W +: BYTE_W])
        );
    end

    always_comb begin
        st_d         = st_q;
        st_d.rd_pend = 1'b0;
        st_d.we      = '0;
        st_d.rvalid  = 1'b0;
        if (st_q.rd_pend) begin
            st_d.latch  = mem_rdata;
            st_d.rdata  = mem_rdata[int'(st_q.rd_plane)*BYTE_W +: BYTE_W];
            st_d.rvalid = 1'b1;
        end
        if (cpu_rd) begin
            st_d.rd_pend  = 1'b1;
            st_d.addr     = cpu_addr;
            st_d.rd_plane = cfg.rd_plane;
        end else if (cpu_wr) begin
            st_d.we    = cfg.plane_en;
            st_d.addr  = cpu_addr;
            st_d.wdata = wr_bytes;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mem_addr   = st_q.addr;
    assign mem_rd     = st_q.rd_pend;
    assign mem_we     = st_q.we;
    assign mem_wdata  = st_q.wdata;
    assign cpu_rdata  = st_q.rdata;
    assign cpu_rvalid = st_q.rvalid;

    // R2: read data appears exactly one cycle after the memory read cycle
    p_rvalid_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> cpu_rvalid);
    p_rvalid_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_rd |=> !cpu_rvalid);

    // R4: latches are only reloaded by a completing read
    p_latch_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.rd_pend |=> $stable(st_q.latch));

    // R7: latch-copy mode writes the held latches
    p_latch_copy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && !cpu_rd && !st_q.rd_pend && cfg.mode == WM_LATCH)
        |=> mem_wdata == $past(st_q.latch));

    // R6: an all-zero mask passes the latches through
    p_mask_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && !cpu_rd && !st_q.rd_pend && cfg.mode == WM_COMBINE
         && cfg.bit_mask == '0) |=> mem_wdata == $past(st_q.latch));

    // R8: write enables follow the plane-enable register
    p_we_enable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && !cpu_rd) |=> mem_we == $past(cfg.plane_en));

    // R9: no write enable without a write strobe one cycle earlier
    p_we_one_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_wr |=> mem_we == '0);

    // R10: a read strobe wins over a simultaneous write strobe
    p_read_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rd |=> (mem_rd && mem_we == '0));
endmodule

// File: tb/planar_write_path_test.sv
`timescale 1ns/1ps
module planar_write_path_test;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic          cpu_rd = 1'b0;
    logic          cpu_wr = 1'b0;
    logic [7:0]    cpu_wdata = '0;
    logic [7:0]    cpu_rdata;
    logic          cpu_rvalid;
    logic          reg_wr = 1'b0;
    logic          reg_sel = 1'b0;
    logic [7:0]    reg_wdata = '0;
    logic [AW-1:0] mem_addr;
    logic          mem_rd;
    logic [3:0]    mem_we;
    logic [31:0]   mem_wdata;
    logic [31:0]   mem_rdata;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    planar_write_path #(.ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n),
        .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_rvalid(cpu_rvalid),
        .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_we(mem_we),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // Bench frame buffer: 64 words, four byte planes each
    logic [31:0] fb [64];
    logic        pl_en = 1'b0;
    logic [5:0]  pl_addr = '0;
    logic [31:0] pl_data = '0;

    assign mem_rdata = fb[mem_addr[5:0]];

    always @(posedge clk) begin
        if (pl_en) begin
            fb[pl_addr] <= pl_data;
        end else begin
            for (int p = 0; p < 4; p++) begin
                if (mem_we[p]) fb[mem_addr[5:0]][p*8 +: 8] <= mem_wdata[p*8 +: 8];
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] ref_bits(input logic [1:0] fn, input logic [7:0] mask,
                                            input logic [7:0] c, input logic [7:0] l);
        logic [7:0] r;
        for (int b = 0; b < 8; b++) begin
            logic v;
            unique case (fn)
                2'd0: v = c[b];
                2'd1: v = c[b] & l[b];
                2'd2: v = c[b] | l[b];
                default: v = c[b] ^ l[b];
            endcase
            r[b] = mask[b] ? v : l[b];
        end
        return r;
    endfunction

    function automatic logic [31:0] ref_word(input logic [1:0] fn, input logic [7:0] mask,
                                             input logic [7:0] c, input logic [31:0] l);
        logic [31:0] w;
        for (int p = 0; p < 4; p++) w[p*8 +: 8] = ref_bits(fn, mask, c, l[p*8 +: 8]);
        return w;
    endfunction

    task automatic preload(input logic [5:0] a, input logic [31:0] d);
        pl_en = 1'b1; pl_addr = a; pl_data = d;
        @(negedge clk);
        pl_en = 1'b0;
    endtask

    task automatic reg_index(input logic [2:0] idx);
        reg_wr = 1'b1; reg_sel = 1'b0; reg_wdata = {5'd0, idx};
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_data(input logic [7:0] v);
        reg_wr = 1'b1; reg_sel = 1'b1; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_set(input logic [2:0] idx, input logic [7:0] v);
        reg_index(idx);
        reg_data(v);
    endtask

    task automatic cpu_read(input logic [5:0] a, output logic [7:0] d);
        cpu_addr = {10'd0, a}; cpu_rd = 1'b1;
        @(negedge clk);
        chk("R2 mem_rd", {31'd0, mem_rd}, 32'd1);
        chk("R2 mem_addr", {16'd0, mem_addr}, {26'd0, a});
        cpu_rd = 1'b0;
        @(negedge clk);
        chk("R2 rvalid", {31'd0, cpu_rvalid}, 32'd1);
        d = cpu_rdata;
    endtask

    task automatic cpu_write(input logic [5:0] a, input logic [7:0] d, output logic [3:0] we_seen);
        cpu_addr = {10'd0, a}; cpu_wdata = d; cpu_wr = 1'b1;
        @(negedge clk);
        we_seen = mem_we;
        chk("R9 mem_addr", {16'd0, mem_addr}, {26'd0, a});
        cpu_wr = 1'b0;
        @(negedge clk);
        chk("R9 we one cycle", {28'd0, mem_we}, 32'd0);
    endtask

    task automatic t_reset();
        logic [3:0] we;
        chk("R1 rvalid", {31'd0, cpu_rvalid}, 32'd0);
        chk("R1 mem_rd", {31'd0, mem_rd}, 32'd0);
        chk("R1 mem_we", {28'd0, mem_we}, 32'd0);
        preload(6'd1, 32'hDEADBEEF);
        cpu_write(6'd1, 8'h5A, we);
        chk("R1 default write", fb[1], 32'h5A5A5A5A);
        chk("R1 default enables", {28'd0, we}, 32'hF);
        preload(6'd2, 32'h12345678);
        reg_set(3'd3, 8'h01);
        cpu_write(6'd2, 8'hFF, we);
        chk("R1 latches zero", fb[2], 32'h0);
        reg_set(3'd3, 8'h00);
    endtask

    task automatic t_read_planes();
        logic [7:0] d;
        preload(6'd5, 32'hC35A0FE1);
        for (int p = 0; p < 4; p++) begin
            reg_set(3'd4, p[7:0]);
            cpu_read(6'd5, d);
            chk("R2 plane byte", {24'd0, d}, {24'd0, 8'(32'hC35A0FE1 >> (p*8))});
        end
        reg_set(3'd4, 8'd0);
    endtask

    task automatic t_latch_load();
        logic [7:0] d;
        logic [3:0] we;
        preload(6'd6, 32'h89ABCDEF);
        reg_set(3'd4, 8'd2);
        cpu_read(6'd6, d);
        reg_set(3'd4, 8'd0);
        reg_set(3'd3, 8'h01);
        cpu_write(6'd22, 8'h00, we);
        chk("R3 all latches loaded", fb[22], 32'h89ABCDEF);
        chk("R7 cpu data ignored", fb[22], 32'h89ABCDEF);
        reg_set(3'd3, 8'h00);
        reg_set(3'd2, 8'h18);
        reg_set(3'd0, 8'h00);
        cpu_write(6'd23, 8'h77, we);
        chk("R6 zero mask", fb[23], 32'h89ABCDEF);
        reg_set(3'd0, 8'hFF);
        cpu_write(6'd24, 8'h33, we);
        cpu_write(6'd24, 8'hCC, we);
        reg_set(3'd2, 8'h00);
        reg_set(3'd3, 8'h01);
        cpu_write(6'd25, 8'h11, we);
        chk("R4 latches survive writes", fb[25], 32'h89ABCDEF);
        reg_set(3'd3, 8'h00);
    endtask

    task automatic t_functions();
        logic [7:0] d;
        logic [3:0] we;
        cpu_read(6'd5, d);
        for (int f = 0; f < 4; f++) begin
            reg_set(3'd2, 8'(f << 3));
            cpu_write(6'd20, 8'h96, we);
            chk("R5 function", fb[20], ref_word(f[1:0], 8'hFF, 8'h96, 32'hC35A0FE1));
        end
        reg_set(3'd2, 8'h18);
        reg_set(3'd0, 8'h3C);
        cpu_write(6'd21, 8'hF0, we);
        chk("R6 partial mask", fb[21], ref_word(2'd3, 8'h3C, 8'hF0, 32'hC35A0FE1));
        reg_set(3'd0, 8'hFF);
        reg_set(3'd2, 8'h00);
    endtask

    task automatic t_plane_enable();
        logic [3:0] we;
        preload(6'd30, 32'h11223344);
        reg_set(3'd1, 8'h05);
        cpu_write(6'd30, 8'hAB, we);
        chk("R8 enables", {28'd0, we}, 32'h5);
        chk("R8 disabled planes kept", fb[30], 32'h11AB33AB);
        reg_set(3'd1, 8'h0F);
    endtask

    task automatic t_rd_wr_collide();
        preload(6'd41, 32'h55667788);
        cpu_addr = 16'd41; cpu_wdata = 8'h00; cpu_rd = 1'b1; cpu_wr = 1'b1;
        @(negedge clk);
        chk("R10 no write", {28'd0, mem_we}, 32'd0);
        chk("R10 read taken", {31'd0, mem_rd}, 32'd1);
        cpu_rd = 1'b0; cpu_wr = 1'b0;
        @(negedge clk);
        chk("R10 read data", {24'd0, cpu_rdata}, 32'h88);
        @(negedge clk);
        chk("R10 memory untouched", fb[41], 32'h55667788);
    endtask

    task automatic t_read_then_write();
        logic [7:0] d;
        cpu_read(6'd5, d);
        preload(6'd42, 32'h0BADF00D);
        reg_set(3'd3, 8'h01);
        cpu_addr = 16'd42; cpu_rd = 1'b1;
        @(negedge clk);
        cpu_rd = 1'b0; cpu_addr = 16'd43; cpu_wr = 1'b1; cpu_wdata = 8'hEE;
        @(negedge clk);
        cpu_wr = 1'b0;
        chk("R11 write enable", {28'd0, mem_we}, 32'hF);
        chk("R11 forwarded latch", mem_wdata, 32'h0BADF00D);
        @(negedge clk);
        chk("R11 stored", fb[43], 32'h0BADF00D);
        reg_set(3'd3, 8'h00);
    endtask

    task automatic t_reg_port();
        logic [7:0] d;
        logic [3:0] we;
        reg_index(3'd6);
        reg_data(8'h00);
        reg_index(3'd7);
        reg_data(8'h00);
        cpu_write(6'd50, 8'h3C, we);
        chk("R12 unused index ignored", fb[50], 32'h3C3C3C3C);
        cpu_read(6'd5, d);
        reg_index(3'd0);
        reg_data(8'hF0);
        reg_data(8'h0F);
        cpu_write(6'd51, 8'hFF, we);
        chk("R12 index kept", fb[51], ref_word(2'd0, 8'h0F, 8'hFF, 32'hC35A0FE1));
        reg_set(3'd0, 8'hFF);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) fb[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_read_planes();
        t_latch_load();
        t_functions();
        t_plane_enable();
        t_rd_wr_collide();
        t_read_then_write();
        t_reg_port();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end
endmodule